// File: doc/BRIEF.md
# Sample Slew Rate Limiter

This block limits how fast a sampled digital waveform may change from one clock to the next. The I and Q sample streams each pass through their own identical lane. In each lane the previous output sample is fed back and subtracted from the new input sample, which gives the step requested for that cycle. That step is clamped to a maximum size and added to the previous output, and the sum is registered as the new output. When the input jumps abruptly, the output therefore approaches it as a ramp over several samples.

The maximum step is picked with a small selection code, and each code stands for a fraction of full scale. Full scale here means the whole two's-complement span of the sample, 2^16. The maximum step is rounded up, so a step from the most negative to the most positive sample takes exactly as many accepted samples as the divisor. The settings go from very strong limiting down to a bypass code, in which the output follows the input directly. The block is placed in a transmit datapath ahead of a power amplifier, where it protects the amplifier from sharp edges.

Top module: `srl_iq_top`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `out_i`, `out_q` and `out_valid` are all zero.
- R2: `out_valid` equals the value `in_valid` had one clock earlier.
- R3: A clock edge with `in_valid` low leaves `out_i` and `out_q` unchanged, whatever the sample and selection inputs carry.
- R4: On an accepted sample (`in_valid` high), each lane's output changes by at most the maximum step of the current `slew_sel` code, except under bypass.
- R5: On an accepted sample where the absolute difference between input and previous output is no larger than the maximum step, the output becomes exactly the input.
- R6: On an accepted sample where the difference exceeds the maximum step, the output moves by exactly the maximum step toward the input. Rising and falling steps are treated alike.
- R7: `slew_sel` codes 1 to 7 select the divisors 2, 4, 5, 10, 20, 50 and 100. The maximum step is ceil(65536 / divisor), which gives 32768, 16384, 13108, 6554, 3277, 1311 and 656.
- R8: `slew_sel` code 0 is bypass: on an accepted sample the output equals the input.
- R9: `slew_sel` codes 8 to 15 behave exactly like code 7, the strongest limiting.
- R10: With code 4, an output at -32768 reaches an input of 32767 on the tenth accepted sample and not before. After the ninth accepted sample it reads 26218.
- R11: The I and Q lanes share `slew_sel` and `in_valid` but otherwise run independently. Each lane's output depends only on its own input history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Signed I input sample |
| in_q | input | 16 | Signed Q input sample |
| slew_sel | input | 4 | Slew-limit selection code |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Signed limited I sample |
| out_q | output | 16 | Signed limited Q sample |

## Verification
The bench aims at the points where the clamp changes over. It applies differences a few counts below the limit, where a design that clamped too early would leave a residual error. It applies full-span steps in both directions, where a 16-bit difference would wrap and send the output the wrong way. The ramp count at the 10% setting is checked at both the ninth and the tenth sample, so an off-by-one in the rounding of the step shows up. Reserved codes, a cycle with valid low, and a reset in the middle of a run are also exercised: a design that treated the reserved codes as bypass, or updated the output on idle cycles, would show a wrong output at the next sample.

// File: rtl/srl_pkg.sv
package srl_pkg;

  localparam int unsigned SAMPLE_W    = 16;
  localparam int unsigned SEL_W       = 4;
  localparam int unsigned BYPASS_CODE = 0;

  // divisor of full scale for each selection code; reserved codes fall to the strongest
  function automatic int unsigned fs_divisor(input int unsigned code);
    case (code)
      1:       return 2;
      2:       return 4;
      3:       return 5;
      4:       return 10;
      5:       return 20;
      6:       return 50;
      default: return 100;
    endcase
  endfunction

  // maximum step rounded up so that a full-span step takes exactly 'divisor' samples
  function automatic int unsigned max_step(input int unsigned code, input int unsigned width);
    int unsigned span;
    int unsigned div;
    span = 32'd1 << width;
    div  = fs_divisor(code);
    return (span + div - 1) / div;
  endfunction

endpackage

// File: rtl/srl_step_sel.sv
module srl_step_sel #(
  parameter int unsigned DATA_W = srl_pkg::SAMPLE_W,
  parameter int unsigned SEL_W  = srl_pkg::SEL_W,
  localparam int unsigned LIM_W = DATA_W + 1,
  localparam int unsigned N_CODES = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  output logic [LIM_W-1:0] limit,
  output logic             bypass
);

  logic [LIM_W-1:0] lut [N_CODES];

  for (genvar c = 0; c < N_CODES; c++) begin : g_code
    assign lut[c] = LIM_W'(srl_pkg::max_step(c, DATA_W));
  end

  always_comb begin
    limit  = lut[sel];
    bypass = (sel == SEL_W'(srl_pkg::BYPASS_CODE));
  end

endmodule

// File: rtl/srl_lane.sv
module srl_lane #(
  parameter int unsigned DATA_W = srl_pkg::SAMPLE_W,
  localparam int unsigned DIFF_W = DATA_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     take,
  input  logic signed [DATA_W-1:0] din,
  input  logic [DIFF_W-1:0]        limit,
  input  logic                     bypass,
  output logic signed [DATA_W-1:0] dout
);

  logic signed [DIFF_W-1:0] delta;
  logic [DIFF_W-1:0]        delta_mag;
  logic signed [DIFF_W-1:0] clamp_step;
  logic signed [DIFF_W-1:0] ramp_sum;
  logic signed [DATA_W-1:0] next_val;

  always_comb begin
    // feedback: requested step is new input minus the last output
    delta     = DIFF_W'(din) - DIFF_W'(dout);
    delta_mag = delta[DIFF_W-1] ? DIFF_W'(-delta) : DIFF_W'(delta);
    clamp_step = delta[DIFF_W-1] ? -$signed(limit) : $signed(limit);
    ramp_sum   = DIFF_W'(dout) + clamp_step;
    if (bypass || (delta_mag <= limit)) begin
      next_val = din;
    end else begin
      next_val = ramp_sum[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (take) begin
      dout <= next_val;
    end
  end

endmodule

// File: rtl/srl_iq_top.sv
module srl_iq_top #(
  parameter int unsigned DATA_W = srl_pkg::SAMPLE_W,
  parameter int unsigned SEL_W  = srl_pkg::SEL_W,
  localparam int unsigned LIM_W = DATA_W + 1,
  localparam int unsigned N_LANES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  input  logic [SEL_W-1:0]         slew_sel,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q
);

  logic [LIM_W-1:0]         step_lim;
  logic                     step_bypass;
  logic signed [DATA_W-1:0] lane_in  [N_LANES];
  logic signed [DATA_W-1:0] lane_out [N_LANES];

  srl_step_sel #(.DATA_W(DATA_W), .SEL_W(SEL_W)) step_sel_i (
    .sel    (slew_sel),
    .limit  (step_lim),
    .bypass (step_bypass)
  );

  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    srl_lane #(.DATA_W(DATA_W)) lane_i (
      .clk    (clk),
      .rst    (rst),
      .take   (in_valid),
      .din    (lane_in[l]),
      .limit  (step_lim),
      .bypass (step_bypass),
      .dout   (lane_out[l])
    );
  end

  assign out_i = lane_out[0];
  assign out_q = lane_out[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

endmodule

// File: rtl/srl_iq_chk.sv
module srl_iq_chk #(
  parameter int unsigned DATA_W = srl_pkg::SAMPLE_W,
  parameter int unsigned SEL_W  = srl_pkg::SEL_W
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_i,
  input logic signed [DATA_W-1:0] in_q,
  input logic [SEL_W-1:0]         slew_sel,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_i,
  input logic signed [DATA_W-1:0] out_q
);

  logic                     ck_take;
  logic                     ck_byp;
  int                       ck_lim;
  int                       ck_in_i, ck_in_q, ck_old_i, ck_old_q;
  int                       move_i, move_q, req_i, req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_take  <= 1'b0;
      ck_byp   <= 1'b0;
      ck_lim   <= 0;
      ck_in_i  <= 0;
      ck_in_q  <= 0;
      ck_old_i <= 0;
      ck_old_q <= 0;
    end else begin
      ck_take  <= in_valid;
      ck_byp   <= (slew_sel == SEL_W'(srl_pkg::BYPASS_CODE));
      ck_lim   <= int'(srl_pkg::max_step(int'(slew_sel), DATA_W));
      ck_in_i  <= int'(in_i);
      ck_in_q  <= int'(in_q);
      ck_old_i <= int'(out_i);
      ck_old_q <= int'(out_q);
    end
  end

  always_comb begin
    move_i = int'(out_i) - ck_old_i;
    move_q = int'(out_q) - ck_old_q;
    req_i  = ck_in_i - ck_old_i;
    req_q  = ck_in_q - ck_old_q;
    if (move_i < 0) move_i = -move_i;
    if (move_q < 0) move_q = -move_q;
    if (req_i < 0) req_i = -req_i;
    if (req_q < 0) req_q = -req_q;
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  // R2
  idle_delay_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
  // R3
  hold_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ck_take |-> (int'(out_i) == ck_old_i) && (int'(out_q) == ck_old_q));
  // R4
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (ck_take && !ck_byp) |-> (move_i <= ck_lim) && (move_q <= ck_lim));
  // R5
  exact_i_chk: assert property (@(posedge clk) disable iff (rst)
    (ck_take && (ck_byp || req_i <= ck_lim)) |-> int'(out_i) == ck_in_i);
  // R5
  exact_q_chk: assert property (@(posedge clk) disable iff (rst)
    (ck_take && (ck_byp || req_q <= ck_lim)) |-> int'(out_q) == ck_in_q);
  // R6
  clamp_i_chk: assert property (@(posedge clk) disable iff (rst)
    (ck_take && !ck_byp && req_i > ck_lim) |-> move_i == ck_lim);
  // R6
  clamp_q_chk: assert property (@(posedge clk) disable iff (rst)
    (ck_take && !ck_byp && req_q > ck_lim) |-> move_q == ck_lim);

endmodule

bind srl_iq_top srl_iq_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) chk_i (.*);

// File: tb/srl_iq_top_tb_top.sv
module srl_iq_top_tb_top;

  localparam int CLK_P = 10;
  localparam int N_VEC = 11;

  logic               clk = 1'b0;
  logic               rst;
  logic               in_valid;
  logic signed [15:0] in_i, in_q;
  logic [3:0]         slew_sel;
  logic               out_valid;
  logic signed [15:0] out_i, out_q;

  int n_run  = 0;
  int n_fail = 0;

  // {sel, in_i, in_q, exp_i, exp_q}; each row is one accepted sample, starting from reset
  localparam logic [67:0] VEC [N_VEC] = '{
    {4'd7,  16'sd1000,   -16'sd1000,  16'sd656,    -16'sd656},    // R6 clamp both signs
    {4'd7,  16'sd1000,   -16'sd1000,  16'sd1000,   -16'sd1000},   // R5 residual 344
    {4'd6,  16'sd5000,   16'sd0,      16'sd2311,   16'sd0},       // R7 1311, R11
    {4'd5,  -16'sd5000,  16'sd0,      -16'sd966,   16'sd0},       // R7 3277
    {4'd3,  16'sd20000,  -16'sd20000, 16'sd12142,  -16'sd13108},  // R7 13108
    {4'd2,  16'sd20000,  -16'sd20000, 16'sd20000,  -16'sd20000},  // R5 under 16384
    {4'd1,  -16'sd32768, 16'sd32767,  -16'sd12768, 16'sd12768},   // R6 wide span
    {4'd0,  16'sd32767,  -16'sd32768, 16'sd32767,  -16'sd32768},  // R8 bypass
    {4'd12, 16'sd0,      16'sd0,      16'sd32111,  -16'sd32112},  // R9 reserved = 656
    {4'd15, 16'sd32000,  -16'sd32000, 16'sd32000,  -16'sd32000},  // R9 within 656
    {4'd4,  16'sd0,      16'sd0,      16'sd25446,  -16'sd25446}   // R7 6554
  };

  srl_iq_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .slew_sel(slew_sel), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] s, input int a, input int b);
    @(negedge clk);
    in_valid = v;
    slew_sel = s;
    in_i     = 16'(a);
    in_q     = 16'(b);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; slew_sel = 4'd0; in_i = '0; in_q = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 out_i in reset", int'(out_i), 0);
    check("R1 out_valid in reset", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 out_q after reset", int'(out_q), 0);

    for (int k = 0; k < N_VEC; k++) begin
      drive(1'b1, VEC[k][67:64], int'($signed(VEC[k][63:48])), int'($signed(VEC[k][47:32])));
      check($sformatf("R4/R5/R6 vec%0d I", k), int'(out_i), int'($signed(VEC[k][31:16])));
      check($sformatf("R11 vec%0d Q", k), int'(out_q), int'($signed(VEC[k][15:0])));
      check("R2 valid follows", int'(out_valid), 1);
    end

    // R3: idle cycle with changed inputs and bypass code
    drive(1'b0, 4'd0, 111, 222);
    check("R3 hold I", int'(out_i), 25446);
    check("R3 hold Q", int'(out_q), -25446);
    check("R2 idle valid", int'(out_valid), 0);

    // R10: full-span ramp at divisor 10
    drive(1'b1, 4'd0, -32768, 0);
    check("R8 preset I", int'(out_i), -32768);
    for (int n = 1; n <= 9; n++) begin
      drive(1'b1, 4'd4, 32767, 0);
      check($sformatf("R10 ramp step %0d", n), int'(out_i), -32768 + n * 6554);
      check("R11 Q stays", int'(out_q), 0);
    end
    check("R10 ninth sample", int'(out_i), 26218);
    drive(1'b1, 4'd4, 32767, 0);
    check("R10 tenth sample", int'(out_i), 32767);

    // R1: reset in the middle of a run
    drive(1'b1, 4'd0, 1234, -1234);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid reset I", int'(out_i), 0);
    check("R1 mid reset Q", int'(out_q), 0);
    check("R1 mid reset valid", int'(out_valid), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule